// File: doc/BRIEF.md
# Floppy Controller Host Register Port

This block is the processor-facing side of a floppy disk controller. A host reaches four byte-wide registers through an 8-bit data bus, an active-low chip select, a read/write line and two address bits. The block decodes each access and controls the bus drivers. It latches command, track, sector and outbound data bytes that the host writes. It serves status, track, sector and inbound data bytes that the host reads.

On the disk side, a byte assembler delivers finished bytes as a one-cycle strobe with a byte value. Each delivered byte raises a data request for DMA. The data request falls when the host takes the byte. If a second byte arrives before the first is taken, a lost-data flag is set. The command engine is outside this block. It receives each written command as a value and a one-cycle pulse, and it reports completion on a done input. Completion raises an interrupt request, which the host clears by reading status or by writing a new command.

The bus is modelled as split input and output vectors plus an output-enable. Chip select and read/write are sampled synchronously to the block clock.

Top module: `fdcHostIf`

## Requirements
- R1: `busOe` is 1 exactly when `csN` is 0 and `rwN` is 1. While `busOe` is 1, `busOut` carries the selected register, and otherwise it is 0. A register write is taken only when both `csN` and `rwN` are 0.
- R2: A host access takes effect once, in the first clock cycle in which `csN` is sampled low after being sampled high. Holding `csN` low for further cycles repeats no effect.
- R3: On reads, address 0 returns status, 1 returns track, 2 returns sector and 3 returns the assembled data byte. On writes, address 0 loads the command, 1 loads track (`trackValue`), 2 loads sector (`sectorValue`) and 3 loads the outbound data byte (`hostByte`).
- R4: An `asmStrobe` loads `asmByte` into the data register and sets `drq`. A host read of address 3 clears `drq`. If that read happens in the same cycle as a strobe, `drq` stays 1 and no loss is flagged.
- R5: A strobe that arrives while `drq` is 1, without a data read in the same cycle, sets the lost-data flag. The new byte replaces the old one.
- R6: The status byte has busy in bit 0, `drq` in bit 1 and lost-data in bit 2. Bits 7 to 3 read 0.
- R7: `cmdDone` sets `intrq` and clears busy.
- R8: A status read or a command write clears `intrq`. When `cmdDone` coincides with a status read, `intrq` ends set. When it coincides with a command write, `intrq` ends clear and busy ends set.
- R9: A command write presents the byte on `cmdValue` with a one-cycle `cmdPulse`. It also sets busy and clears lost-data and `drq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rwN | input | 1 | 1 = host read, 0 = host write |
| addr | input | 2 | Register select |
| busIn | input | 8 | Bus value driven by the host |
| busOut | output | 8 | Bus value driven by the block |
| busOe | output | 1 | Enable for the block's bus drivers |
| asmStrobe | input | 1 | Byte assembler has a finished byte |
| asmByte | input | 8 | Finished byte from the assembler |
| cmdDone | input | 1 | Command engine completion pulse |
| drq | output | 1 | Data request for DMA |
| intrq | output | 1 | Interrupt request |
| cmdValue | output | 8 | Last command byte written |
| cmdPulse | output | 1 | One-cycle pulse on a command write |
| trackValue | output | 8 | Track register |
| sectorValue | output | 8 | Sector register |
| hostByte | output | 8 | Outbound data byte written by the host |

## Verification
The bench targets same-cycle collisions between the host and the disk side. One case is a data read landing on the same edge as a new byte: a design that lets the clear win would drop `drq` with an unread byte waiting, or would flag a loss that did not occur. Another is completion coinciding with a status read or with a new command: a wrong priority would leave a stale interrupt or lose a completion. A long chip-select hold followed by a new strobe exposes a design that decodes on level rather than on edge, since such a design would clear `drq` a second time. Overruns, with lost-data cleared by the next command, check that the flag is both sticky and clearable.

// File: rtl/fdcHostPkg.sv
package fdcHostPkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  // register addresses (read and write maps share indices)
  localparam logic [ADDR_W-1:0] REG_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] REG_TRACK  = 2'd1;
  localparam logic [ADDR_W-1:0] REG_SECTOR = 2'd2;
  localparam logic [ADDR_W-1:0] REG_DATA   = 2'd3;

  // status bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_DRQ  = 1;
  localparam int ST_LOST = 2;

  typedef struct packed {
    logic rdStatus;
    logic rdData;
    logic wrCmd;
    logic wrTrack;
    logic wrSector;
    logic wrData;
  } hostStrobes_t;
endpackage

// File: rtl/fdcHostCtrl.sv
module fdcHostCtrl
  import fdcHostPkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          rwN,
  input  logic [AW-1:0] addr,
  output logic          busOe,
  output hostStrobes_t  strobes
);
  localparam int N_REGS = 1 << AW;

  logic csPrevN;
  logic accessPulse;
  logic [N_REGS-1:0] sel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csPrevN <= 1'b1;
    else       csPrevN <= csN;
  end

  // one pulse per falling edge of chip select
  assign accessPulse = csPrevN & ~csN;
  assign busOe = ~csN & rwN;

  genvar gi;
  generate
    for (gi = 0; gi < N_REGS; gi++) begin : gSel
      assign sel[gi] = accessPulse && (addr == AW'(gi));
    end
  endgenerate

  always_comb begin
    strobes          = '0;
    strobes.rdStatus = sel[REG_CTRL]   &  rwN;
    strobes.rdData   = sel[REG_DATA]   &  rwN;
    strobes.wrCmd    = sel[REG_CTRL]   & ~rwN;
    strobes.wrTrack  = sel[REG_TRACK]  & ~rwN;
    strobes.wrSector = sel[REG_SECTOR] & ~rwN;
    strobes.wrData   = sel[REG_DATA]   & ~rwN;
  end

  // R2: an access never lasts two cycles
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    accessPulse |=> !accessPulse);
  // R1: no write strobe while the bus is driven outward
  a_r1_no_write_when_driving: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> !(strobes.wrCmd || strobes.wrTrack || strobes.wrSector || strobes.wrData));
endmodule

// File: rtl/fdcHostDatapath.sv
module fdcHostDatapath
  import fdcHostPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  hostStrobes_t  strobes,
  input  logic          busOe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] busIn,
  output logic [DW-1:0] busOut,
  input  logic          asmStrobe,
  input  logic [DW-1:0] asmByte,
  input  logic          cmdDone,
  output logic          drq,
  output logic          intrq,
  output logic [DW-1:0] cmdValue,
  output logic          cmdPulse,
  output logic [DW-1:0] trackValue,
  output logic [DW-1:0] sectorValue,
  output logic [DW-1:0] hostByte
);
  logic [DW-1:0] dataReg;
  logic busy, lostData;
  logic [DW-1:0] statusByte;

  // host-written registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValue    <= '0;
      cmdPulse    <= 1'b0;
      trackValue  <= '0;
      sectorValue <= '0;
      hostByte    <= '0;
    end else begin
      cmdPulse <= strobes.wrCmd;
      if (strobes.wrCmd)    cmdValue    <= busIn;
      if (strobes.wrTrack)  trackValue  <= busIn;
      if (strobes.wrSector) sectorValue <= busIn;
      if (strobes.wrData)   hostByte    <= busIn;
    end
  end

  // disk-side byte handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      drq      <= 1'b0;
      lostData <= 1'b0;
    end else begin
      if (asmStrobe) dataReg <= asmByte;
      if (asmStrobe)                          drq <= 1'b1;
      else if (strobes.rdData || strobes.wrCmd) drq <= 1'b0;
      if (strobes.wrCmd)                              lostData <= 1'b0;
      else if (asmStrobe && drq && !strobes.rdData)   lostData <= 1'b1;
    end
  end

  // command lifecycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      intrq <= 1'b0;
    end else begin
      if (strobes.wrCmd)         intrq <= 1'b0;
      else if (cmdDone)          intrq <= 1'b1;
      else if (strobes.rdStatus) intrq <= 1'b0;
      if (strobes.wrCmd)  busy <= 1'b1;
      else if (cmdDone)   busy <= 1'b0;
    end
  end

  always_comb begin
    statusByte          = '0;
    statusByte[ST_BUSY] = busy;
    statusByte[ST_DRQ]  = drq;
    statusByte[ST_LOST] = lostData;
  end

  always_comb begin
    busOut = '0;
    if (busOe) begin
      unique case (addr)
        REG_CTRL:   busOut = statusByte;
        REG_TRACK:  busOut = trackValue;
        REG_SECTOR: busOut = sectorValue;
        default:    busOut = dataReg;
      endcase
    end
  end

  // R4: a strobe always leaves a request pending
  a_r4_strobe_sets_drq: assert property (@(posedge clk) disable iff (!rstN)
    asmStrobe |=> drq);
  // R4: a data read with no new byte drops the request
  a_r4_read_clears_drq: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdData && !asmStrobe) |=> !drq);
  // R5: overrun is flagged
  a_r5_overrun_flag: assert property (@(posedge clk) disable iff (!rstN)
    (asmStrobe && drq && !strobes.rdData && !strobes.wrCmd) |=> lostData);
  // R7: completion raises the interrupt unless a command is written
  a_r7_done_sets_irq: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && !strobes.wrCmd) |=> (intrq && !busy));
  // R8: status read without completion clears the interrupt
  a_r8_status_clears_irq: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStatus && !cmdDone) |=> !intrq);
  // R9: command write leaves busy set and a one-cycle pulse
  a_r9_cmd_effects: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrCmd |=> (busy && cmdPulse && !lostData && !intrq));
endmodule

// File: rtl/fdcHostIf.sv
module fdcHostIf
  import fdcHostPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          rwN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] busIn,
  output logic [DW-1:0] busOut,
  output logic          busOe,
  input  logic          asmStrobe,
  input  logic [DW-1:0] asmByte,
  input  logic          cmdDone,
  output logic          drq,
  output logic          intrq,
  output logic [DW-1:0] cmdValue,
  output logic          cmdPulse,
  output logic [DW-1:0] trackValue,
  output logic [DW-1:0] sectorValue,
  output logic [DW-1:0] hostByte
);
  hostStrobes_t strobes;

  fdcHostCtrl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rwN(rwN), .addr(addr),
    .busOe(busOe), .strobes(strobes)
  );

  fdcHostDatapath #(.DW(DW), .AW(AW)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busOe(busOe), .addr(addr),
    .busIn(busIn), .busOut(busOut), .asmStrobe(asmStrobe), .asmByte(asmByte),
    .cmdDone(cmdDone), .drq(drq), .intrq(intrq), .cmdValue(cmdValue),
    .cmdPulse(cmdPulse), .trackValue(trackValue), .sectorValue(sectorValue),
    .hostByte(hostByte)
  );
endmodule

// File: tb/tb_fdcHostIf.sv
module tb_fdcHostIf;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rwN = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] busIn = '0, asmByte = '0;
  logic asmStrobe = 1'b0, cmdDone = 1'b0;
  logic [7:0] busOut, cmdValue, trackValue, sectorValue, hostByte;
  logic busOe, drq, intrq, cmdPulse;

  int nTests = 0, nFail = 0;

  // reference model state
  bit mPrevCs = 1, mDrq = 0, mIrq = 0, mBusy = 0, mLost = 0, mPulse = 0;
  int mData = 0, mCmd = 0, mTrack = 0, mSector = 0, mHost = 0;

  always #10 clk = ~clk;

  fdcHostIf dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rwN(rwN), .addr(addr), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .asmStrobe(asmStrobe), .asmByte(asmByte),
    .cmdDone(cmdDone), .drq(drq), .intrq(intrq), .cmdValue(cmdValue),
    .cmdPulse(cmdPulse), .trackValue(trackValue), .sectorValue(sectorValue),
    .hostByte(hostByte)
  );

  task automatic chk(string req, string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int expBus();
    if (csN || !rwN) return 0;
    case (addr)
      2'd0: return {mLost, mDrq, mBusy};  // R6 layout: bit2 lost, bit1 drq, bit0 busy
      2'd1: return mTrack;
      2'd2: return mSector;
      default: return mData;
    endcase
  endfunction

  task automatic compareAll();
    chk("R1", "busOe", int'(busOe), int'(!csN && rwN));
    chk("R3", "busOut", int'(busOut), expBus());
    chk("R4", "drq", int'(drq), int'(mDrq));
    chk("R7", "intrq", int'(intrq), int'(mIrq));
    chk("R9", "cmdPulse", int'(cmdPulse), int'(mPulse));
    chk("R9", "cmdValue", int'(cmdValue), mCmd);
    chk("R3", "trackValue", int'(trackValue), mTrack);
    chk("R3", "sectorValue", int'(sectorValue), mSector);
    chk("R3", "hostByte", int'(hostByte), mHost);
  endtask

  // one clock: model next state from current inputs, then compare
  task automatic step();
    bit pulse, rdS, rdD, wC;
    bit nDrq, nIrq, nBusy, nLost;
    pulse = mPrevCs && !csN;                     // R2: edge, not level
    rdS = pulse && rwN && addr == 0;
    rdD = pulse && rwN && addr == 3;
    wC  = pulse && !rwN && addr == 0;
    nDrq = asmStrobe ? 1 : ((rdD || wC) ? 0 : mDrq);
    nLost = wC ? 0 : ((asmStrobe && mDrq && !rdD) ? 1 : mLost);   // R5
    nIrq = wC ? 0 : (cmdDone ? 1 : (rdS ? 0 : mIrq));             // R8
    nBusy = wC ? 1 : (cmdDone ? 0 : mBusy);
    @(posedge clk);
    if (asmStrobe) mData = asmByte;
    if (pulse && !rwN) begin
      case (addr)
        2'd0: mCmd = busIn;
        2'd1: mTrack = busIn;
        2'd2: mSector = busIn;
        default: mHost = busIn;
      endcase
    end
    mPulse = wC; mDrq = nDrq; mLost = nLost; mIrq = nIrq; mBusy = nBusy;
    mPrevCs = csN;
    #2;
    compareAll();
    @(negedge clk);
  endtask

  // host access with optional same-cycle disk events on the first cycle
  task automatic access(bit rd, int a, int val, int hold, bit asmFirst, int asmVal, bit doneFirst);
    csN = 0; rwN = rd; addr = 2'(a); busIn = 8'(val);
    asmStrobe = asmFirst; asmByte = 8'(asmVal); cmdDone = doneFirst;
    #1 compareAll();   // combinational read path while selected
    step();
    asmStrobe = 0; cmdDone = 0;
    for (int i = 1; i < hold; i++) step();
    csN = 1; rwN = 1;
    step();
  endtask

  task automatic diskByte(int v);
    asmStrobe = 1; asmByte = 8'(v); step(); asmStrobe = 0; step();
  endtask

  task automatic done();
    cmdDone = 1; step(); cmdDone = 0; step();
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    compareAll();                       // reset state, all R3/R4/R7/R9 outputs at 0
    repeat (2) @(negedge clk);
    rstN = 1;
    step();
    // R3: write track, sector, data; read them back
    access(0, 1, 8'h27, 1, 0, 0, 0);
    access(0, 2, 8'h09, 1, 0, 0, 0);
    access(0, 3, 8'hC3, 1, 0, 0, 0);
    access(1, 1, 0, 2, 0, 0, 0);
    access(1, 2, 0, 2, 0, 0, 0);
    // R9: command write sets busy and pulses
    access(0, 0, 8'h80, 1, 0, 0, 0);
    access(1, 0, 0, 1, 0, 0, 0);        // R6 status busy=1
    // R7: completion
    done();
    chk("R7", "intrq after done", int'(intrq), 1);
    access(1, 0, 0, 1, 0, 0, 0);        // R8 status read clears
    chk("R8", "intrq after status read", int'(intrq), 0);
    // R4: byte then read
    diskByte(8'h5A);
    access(1, 3, 0, 1, 0, 0, 0);
    chk("R4", "drq after data read", int'(drq), 0);
    // R5: overrun
    diskByte(8'h11); diskByte(8'h22);
    access(1, 0, 0, 1, 0, 0, 0);        // status shows lost+drq
    access(1, 3, 0, 1, 0, 0, 0);        // reads 0x22
    // R4: read and strobe in same cycle
    diskByte(8'h33);
    access(1, 3, 0, 1, 1, 8'h44, 0);
    chk("R4", "drq kept on collision", int'(drq), 1);
    access(1, 0, 0, 1, 0, 0, 0);        // lost stays clear? (lost still set from earlier)
    // R9: command clears lost and drq
    access(0, 0, 8'h10, 1, 0, 0, 0);
    chk("R9", "drq cleared by command", int'(drq), 0);
    // R8: done coincides with status read -> irq set
    access(1, 0, 0, 1, 0, 0, 1);
    chk("R8", "done beats status read", int'(intrq), 1);
    // R8: done coincides with command write -> irq clear, busy set
    access(0, 0, 8'hA5, 1, 0, 0, 1);
    chk("R8", "command beats done", int'(intrq), 0);
    done();
    // R2: long hold; new byte while still selected must not be cleared again
    diskByte(8'h66);
    csN = 0; rwN = 1; addr = 2'd3;
    step(); step();
    asmStrobe = 1; asmByte = 8'h77; step(); asmStrobe = 0;
    step(); step();
    chk("R2", "drq not re-cleared during hold", int'(drq), 1);
    csN = 1; step();
    // R1: write while driving inward, bus quiet
    access(0, 1, 8'h3C, 3, 0, 0, 0);
    // mixed pattern driven by a bench LFSR
    begin
      int lfsr = 32'h1ACE;
      for (int n = 0; n < 400; n++) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        case (lfsr % 6)
          0: diskByte(lfsr >> 4);
          1: done();
          2: access(1, lfsr >> 8, 0, 1 + (lfsr >> 12) % 3, (lfsr >> 3) & 1, lfsr >> 5, (lfsr >> 7) & 1);
          3: access(0, lfsr >> 8, lfsr >> 2, 1 + (lfsr >> 12) % 2, (lfsr >> 3) & 1, lfsr >> 5, (lfsr >> 7) & 1);
          default: step();
        endcase
      end
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule